// File: doc/BRIEF.md
# Tile Copy Command Sequencer

This block moves an image, one tile at a time, between a source buffer and a destination buffer in external memory. Software programs a small register bank with the source base address, the destination base address, the tile length in bytes, the number of tiles and a rotation mode. A write to the start bit then begins the operation. For each tile the block issues one read command, followed by one write command, on a simple memory command port.

Every command follows the same four steps. The block raises a request. The memory side acknowledges it. The block's attribute outputs (direction, beat or burst, address, byte enables, length) describe the command. The memory side then signals completion. Only one command is in flight at any time, and the pixel work between the read and the write is done elsewhere. The block exports the captured rotation mode to that processing stage. When the last tile has been written back, the block raises an interrupt line. The line stays high until software clears it.

Top module: `tdma_top`

## Requirements
- R1: The register bank is word-addressed by the 3-bit `regAddr`. Its layout is: 0 source base, 1 destination base, 2 tile count (16 bits), 3 tile length in bytes (12 bits, resets to 30), 4 rotation mode (2 bits), 5 control (bit 0 start, write-only, reads 0), 6 status (bit 0 interrupt, bit 1 busy), 7 counters (bits 15:0 completed reads, bits 31:16 completed writes). Every register except the length resets to 0. Read data is combinational from `regAddr`.
- R2: `cmdBurst` is 1 when the captured length exceeds the 4 bytes of one data beat. A burst drives all four byte enables. A single beat of length L enables only bytes 0 to L-1.
- R3: A request stays asserted, with unchanged attributes, until the cycle in which it is acknowledged.
- R4: Only one command is outstanding. After an acknowledge, no new request appears until the completion. Commands alternate read, write, read, write, and so on.
- R5: Read addresses start at the source base and write addresses start at the destination base. Each pointer advances by the tile length after each completion of its own kind. `cmdLen` equals the captured length.
- R6: The operation ends at the write completion that brings the write count up to the captured tile count. A start with a tile count of 0 finishes at once, without issuing any command.
- R7: Both completion counters read 0 whenever the block is idle.
- R8: The interrupt sets on the clock edge that ends an operation. It holds until a status write with bit 0 at 1. If a set and a clear fall in the same cycle, the set wins.
- R9: A start written while busy is ignored. Writes to the configuration registers during an operation change their readback but not the running operation.
- R10: `rotMode` presents the mode captured at start and holds it for the whole operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data |
| cmdReq | output | 1 | Command request |
| cmdWrite | output | 1 | Command direction, 1 = write |
| cmdBurst | output | 1 | 1 = burst, 0 = single beat |
| cmdAddr | output | 32 | Command byte address |
| cmdBe | output | 4 | Command byte enables |
| cmdLen | output | 12 | Command length in bytes |
| cmdAck | input | 1 | Command acknowledge |
| cmdCmplt | input | 1 | Command completion |
| rotMode | output | 2 | Captured rotation mode |
| irq | output | 1 | Operation-finished interrupt |

## Verification
A corrupted sequencing state shows up on the command port on the very next cycle. It appears as a request while a command is outstanding, as a write where a read belongs, or as a missing request. A wrong pointer or length register appears in the address or length attributes of the next command. A miscounted tile total surfaces as an early or late interrupt, one tile-time off. Counters that fail to clear become visible at the first counter readback after the operation ends.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] REG_SRC    = 3'd0;
  localparam logic [REG_AW-1:0] REG_DST    = 3'd1;
  localparam logic [REG_AW-1:0] REG_TOTAL  = 3'd2;
  localparam logic [REG_AW-1:0] REG_LEN    = 3'd3;
  localparam logic [REG_AW-1:0] REG_MODE   = 3'd4;
  localparam logic [REG_AW-1:0] REG_CTRL   = 3'd5;
  localparam logic [REG_AW-1:0] REG_STATUS = 3'd6;
  localparam logic [REG_AW-1:0] REG_COUNT  = 3'd7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT
  } tdmaState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic launch;   // capture config, load pointers
    logic rdDone;   // read completed
    logic wrDone;   // write completed
    logic finish;   // operation over: set interrupt, clear counters
  } tdmaStrobe_t;
endpackage

// File: rtl/tdma_ctrl.sv
module tdma_ctrl
  import tdma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        totalZero,
  input  logic        lastBurst,
  input  logic        cmdAck,
  input  logic        cmdCmplt,
  output logic        cmdReq,
  output logic        cmdWrite,
  output logic        busy,
  output tdmaStrobe_t strobe
);
  tdmaState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          if (totalZero) begin
            strobe.finish = 1'b1;
          end else begin
            strobe.launch = 1'b1;
            stateNext     = ST_RD_REQ;
          end
        end
      end
      ST_RD_REQ:  if (cmdAck) stateNext = ST_RD_WAIT;
      ST_RD_WAIT: begin
        if (cmdCmplt) begin
          strobe.rdDone = 1'b1;
          stateNext     = ST_WR_REQ;
        end
      end
      ST_WR_REQ:  if (cmdAck) stateNext = ST_WR_WAIT;
      ST_WR_WAIT: begin
        if (cmdCmplt) begin
          strobe.wrDone = 1'b1;
          if (lastBurst) begin
            strobe.finish = 1'b1;
            stateNext     = ST_IDLE;
          end else begin
            stateNext = ST_RD_REQ;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign cmdReq   = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign cmdWrite = (state == ST_WR_REQ) || (state == ST_WR_WAIT);
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/tdma_path.sv
module tdma_path
  import tdma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 12,
  parameter int CNT_W     = 16,
  parameter int MODE_W    = 2,
  parameter int LEN_RESET = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWrData,
  output logic [REG_DW-1:0] regRdData,
  input  tdmaStrobe_t       strobe,
  input  logic              busy,
  input  logic              cmdWrite,
  output logic              startReq,
  output logic              totalZero,
  output logic              lastBurst,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [LEN_W-1:0]  cmdLen,
  output logic              cmdBurst,
  output logic [DATA_W/8-1:0] cmdBe,
  output logic [MODE_W-1:0] rotMode,
  output logic              irq,
  output logic [CNT_W-1:0]  rdCount,
  output logic [CNT_W-1:0]  wrCount
);
  localparam int BYTES = DATA_W / 8;

  logic [ADDR_W-1:0] srcReg, dstReg, rdPtr, wrPtr;
  logic [CNT_W-1:0]  totalReg, actTotal;
  logic [LEN_W-1:0]  lenReg, actLen;
  logic [MODE_W-1:0] modeReg, actMode;
  logic              irqFlag;
  logic              clearIrq;

  assign startReq  = regWrEn && (regAddr == REG_CTRL) && regWrData[0];
  assign clearIrq  = regWrEn && (regAddr == REG_STATUS) && regWrData[0];
  assign totalZero = (totalReg == '0);
  assign lastBurst = (CNT_W'(wrCount + 1'b1) == actTotal);

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg   <= '0;
      dstReg   <= '0;
      totalReg <= '0;
      lenReg   <= LEN_W'(LEN_RESET);
      modeReg  <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        REG_SRC:   srcReg   <= regWrData[ADDR_W-1:0];
        REG_DST:   dstReg   <= regWrData[ADDR_W-1:0];
        REG_TOTAL: totalReg <= regWrData[CNT_W-1:0];
        REG_LEN:   lenReg   <= regWrData[LEN_W-1:0];
        REG_MODE:  modeReg  <= regWrData[MODE_W-1:0];
        default: ;
      endcase
    end
  end

  // operation snapshot and pointers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actTotal <= '0;
      actLen   <= '0;
      actMode  <= '0;
      rdPtr    <= '0;
      wrPtr    <= '0;
    end else begin
      if (strobe.launch) begin
        actTotal <= totalReg;
        actLen   <= lenReg;
        actMode  <= modeReg;
        rdPtr    <= srcReg;
        wrPtr    <= dstReg;
      end
      if (strobe.rdDone) rdPtr <= rdPtr + ADDR_W'(actLen);
      if (strobe.wrDone) wrPtr <= wrPtr + ADDR_W'(actLen);
    end
  end

  // completion counters, cleared at the end of every operation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdCount <= '0;
      wrCount <= '0;
    end else if (strobe.finish) begin
      rdCount <= '0;
      wrCount <= '0;
    end else begin
      if (strobe.rdDone) rdCount <= rdCount + 1'b1;
      if (strobe.wrDone) wrCount <= wrCount + 1'b1;
    end
  end

  // interrupt: set has priority over the software clear
  always_ff @(posedge clk) begin
    if (!rstN)              irqFlag <= 1'b0;
    else if (strobe.finish) irqFlag <= 1'b1;
    else if (clearIrq)      irqFlag <= 1'b0;
  end

  assign irq      = irqFlag;
  assign rotMode  = actMode;
  assign cmdLen   = actLen;
  assign cmdAddr  = cmdWrite ? wrPtr : rdPtr;
  assign cmdBurst = (actLen > LEN_W'(BYTES));

  for (genvar b = 0; b < BYTES; b++) begin : g_be
    assign cmdBe[b] = cmdBurst || (actLen > LEN_W'(b));
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_SRC:    regRdData = REG_DW'(srcReg);
      REG_DST:    regRdData = REG_DW'(dstReg);
      REG_TOTAL:  regRdData = REG_DW'(totalReg);
      REG_LEN:    regRdData = REG_DW'(lenReg);
      REG_MODE:   regRdData = REG_DW'(modeReg);
      REG_STATUS: regRdData = REG_DW'({busy, irqFlag});
      REG_COUNT:  regRdData = REG_DW'({wrCount[15:0], rdCount[15:0]});
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/tdma_top.sv
module tdma_top
  import tdma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 12,
  parameter int CNT_W     = 16,
  parameter int MODE_W    = 2,
  parameter int LEN_RESET = 30
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [REG_DW-1:0]   regWrData,
  output logic [REG_DW-1:0]   regRdData,
  output logic                cmdReq,
  output logic                cmdWrite,
  output logic                cmdBurst,
  output logic [ADDR_W-1:0]   cmdAddr,
  output logic [DATA_W/8-1:0] cmdBe,
  output logic [LEN_W-1:0]    cmdLen,
  input  logic                cmdAck,
  input  logic                cmdCmplt,
  output logic [MODE_W-1:0]   rotMode,
  output logic                irq
);
  tdmaStrobe_t       strobe;
  logic              startReq, totalZero, lastBurst, busy;
  logic [CNT_W-1:0]  rdCount, wrCount;

  tdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .startReq(startReq), .totalZero(totalZero), .lastBurst(lastBurst),
    .cmdAck(cmdAck), .cmdCmplt(cmdCmplt),
    .cmdReq(cmdReq), .cmdWrite(cmdWrite), .busy(busy), .strobe(strobe)
  );

  tdma_path #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
    .MODE_W(MODE_W), .LEN_RESET(LEN_RESET)
  ) u_path (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .strobe(strobe), .busy(busy), .cmdWrite(cmdWrite),
    .startReq(startReq), .totalZero(totalZero), .lastBurst(lastBurst),
    .cmdAddr(cmdAddr), .cmdLen(cmdLen), .cmdBurst(cmdBurst), .cmdBe(cmdBe),
    .rotMode(rotMode), .irq(irq), .rdCount(rdCount), .wrCount(wrCount)
  );
endmodule

// File: rtl/tdma_checker.sv
module tdma_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [2:0]        regAddr,
  input logic [31:0]       regWrData,
  input logic              cmdReq,
  input logic              cmdWrite,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic              cmdAck,
  input logic              cmdCmplt,
  input logic [MODE_W-1:0] rotMode,
  input logic              irq,
  input logic              busy,
  input logic [CNT_W-1:0]  rdCount,
  input logic [CNT_W-1:0]  wrCount
);
  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && !cmdAck) |=> cmdReq);

  assert_attr_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && !cmdAck) |=> ($stable(cmdAddr) && $stable(cmdWrite)));

  assert_single_outstanding_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && cmdAck) |=> !cmdReq);

  assert_idle_counts_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (rdCount == '0 && wrCount == '0));

  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(regWrEn && regAddr == 3'd6 && regWrData[0])) |=> irq);

  assert_mode_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || $stable(rotMode)));
endmodule

bind tdma_top tdma_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .cmdReq(cmdReq), .cmdWrite(cmdWrite), .cmdAddr(cmdAddr), .cmdAck(cmdAck),
  .cmdCmplt(cmdCmplt), .rotMode(rotMode), .irq(irq), .busy(busy),
  .rdCount(rdCount), .wrCount(wrCount)
);

// File: tb/sim_tdma_top.sv
`timescale 1ns/1ps
module sim_tdma_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        cmdReq, cmdWrite, cmdBurst, irq;
  logic [31:0] cmdAddr;
  logic [3:0]  cmdBe;
  logic [11:0] cmdLen;
  logic        cmdAck = 1'b0;
  logic        cmdCmplt = 1'b0;
  logic [1:0]  rotMode;

  integer checks = 0;
  integer errors = 0;
  bit     done = 0;

  always #4 clk = ~clk;   // 125 MHz

  tdma_top u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .cmdReq(cmdReq), .cmdWrite(cmdWrite), .cmdBurst(cmdBurst),
    .cmdAddr(cmdAddr), .cmdBe(cmdBe), .cmdLen(cmdLen), .cmdAck(cmdAck), .cmdCmplt(cmdCmplt),
    .rotMode(rotMode), .irq(irq)
  );

  // reference model
  integer mSt, mTotal, mLen, mMode, mActTotal, mActLen, mActMode, mRd, mWr;
  logic [31:0] mSrc, mDst, mRdPtr, mWrPtr;
  bit mIrq;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit startW, clrW, setIrq;
    if (!rstN) begin
      mSt = 0; mSrc = 0; mDst = 0; mTotal = 0; mLen = 30; mMode = 0;
      mActTotal = 0; mActLen = 0; mActMode = 0; mRd = 0; mWr = 0;
      mRdPtr = 0; mWrPtr = 0; mIrq = 0;
    end else begin
      startW = regWrEn && regAddr == 3'd5 && regWrData[0];
      clrW   = regWrEn && regAddr == 3'd6 && regWrData[0];
      setIrq = 0;
      case (mSt)
        0: if (startW) begin
             if (mTotal == 0) setIrq = 1;
             else begin
               mRdPtr = mSrc; mWrPtr = mDst; mActTotal = mTotal;
               mActLen = mLen; mActMode = mMode; mSt = 1;
             end
           end
        1: if (cmdAck) mSt = 2;
        2: if (cmdCmplt) begin mRd++; mRdPtr = mRdPtr + mActLen; mSt = 3; end
        3: if (cmdAck) mSt = 4;
        4: if (cmdCmplt) begin
             mWrPtr = mWrPtr + mActLen;
             if (mWr + 1 == mActTotal) begin mWr = 0; mRd = 0; mSt = 0; setIrq = 1; end
             else begin mWr++; mSt = 1; end
           end
        default: mSt = 0;
      endcase
      if (regWrEn) case (regAddr)
        3'd0: mSrc = regWrData;
        3'd1: mDst = regWrData;
        3'd2: mTotal = regWrData[15:0];
        3'd3: mLen = regWrData[11:0];
        3'd4: mMode = regWrData[1:0];
        default: ;
      endcase
      if (setIrq) mIrq = 1; else if (clrW) mIrq = 0;
    end
    #2;
    if (rstN) begin
      bit expWr, expBurst;
      logic [3:0] expBe;
      expWr = (mSt >= 3);
      expBurst = (mActLen > 4);
      for (int b = 0; b < 4; b++) expBe[b] = expBurst || (mActLen > b);
      chk(cmdReq == (mSt == 1 || mSt == 3), "R3 R4 cmdReq", cmdReq, (mSt == 1 || mSt == 3));
      chk(cmdWrite == expWr, "R4 cmdWrite", cmdWrite, expWr);
      chk(cmdAddr == (expWr ? mWrPtr : mRdPtr), "R5 cmdAddr", cmdAddr, expWr ? mWrPtr : mRdPtr);
      chk(cmdLen == 12'(mActLen), "R5 cmdLen", cmdLen, mActLen);
      chk(cmdBurst == expBurst, "R2 cmdBurst", cmdBurst, expBurst);
      chk(cmdBe == expBe, "R2 cmdBe", cmdBe, expBe);
      chk(rotMode == 2'(mActMode), "R10 rotMode", rotMode, mActMode);
      chk(irq == mIrq, "R6 R8 irq", irq, mIrq);
    end
  end

  // memory-side responder
  integer ackDelay = 0, cmplDelay = 0, rPh = 0, rCnt = 0;
  always @(negedge clk) begin
    cmdAck = 0; cmdCmplt = 0;
    if (!rstN) begin rPh = 0; rCnt = 0; end
    else if (rPh == 0) begin
      if (cmdReq) begin
        if (rCnt >= ackDelay) begin cmdAck = 1; rPh = 1; rCnt = 0; end
        else rCnt++;
      end
    end else begin
      if (rCnt >= cmplDelay) begin cmdCmplt = 1; rPh = 0; rCnt = 0; end
      else rCnt++;
    end
  end

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic readCheck(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(regRdData == exp, tag, regRdData, exp);
  endtask

  task automatic waitIrq();
    for (int n = 0; n < 5000 && !irq; n++) @(negedge clk);
  endtask

  task automatic runOp(input logic [31:0] src, input logic [31:0] dst, input int total,
                       input int len, input int mode);
    regWrite(3'd0, src);
    regWrite(3'd1, dst);
    regWrite(3'd2, total);
    regWrite(3'd3, len);
    regWrite(3'd4, mode);
    regWrite(3'd5, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    // reset state
    readCheck(3'd0, 0, "R1 src reset");
    readCheck(3'd3, 30, "R1 len reset");
    readCheck(3'd6, 0, "R1 status reset");
    readCheck(3'd7, 0, "R7 counts reset");
    readCheck(3'd5, 0, "R1 ctrl reads zero");

    // burst operation, three tiles
    ackDelay = 1; cmplDelay = 2;
    runOp(32'h1000, 32'h8000, 3, 30, 2);
    readCheck(3'd2, 3, "R1 total readback");
    readCheck(3'd4, 2, "R1 mode readback");
    readCheck(3'd6, 2, "R1 busy in status");
    waitIrq();
    chk(irq == 1, "R6 irq after three tiles", irq, 1);
    readCheck(3'd6, 1, "R8 status after finish");
    readCheck(3'd7, 0, "R7 counts idle");

    // clear semantics
    regWrite(3'd6, 0);
    readCheck(3'd6, 1, "R8 write 0 keeps irq");
    regWrite(3'd6, 1);
    readCheck(3'd6, 0, "R8 write 1 clears irq");

    // single-beat operation with start and config writes while busy
    ackDelay = 0; cmplDelay = 0;
    runOp(32'h200, 32'h400, 4, 4, 1);
    repeat (3) @(negedge clk);
    regWrite(3'd5, 1);
    regWrite(3'd2, 9);
    regWrite(3'd4, 3);
    readCheck(3'd2, 9, "R9 total readback changes");
    readCheck(3'd7, {16'(mWr), 16'(mRd)}, "R7 counts mid-operation");
    chk(rotMode == 2'd1, "R10 mode held", rotMode, 1);
    waitIrq();
    chk(irq == 1, "R9 op ends at captured total", irq, 1);
    regWrite(3'd6, 1);

    // zero tile count
    regWrite(3'd2, 0);
    regWrite(3'd5, 1);
    chk(irq == 1 && cmdReq == 0, "R6 zero total finishes", {irq, cmdReq}, 2'b10);
    regWrite(3'd6, 1);

    // partial single beat, slow responder
    ackDelay = 3; cmplDelay = 5;
    runOp(32'h30, 32'h90, 2, 3, 0);
    waitIrq();
    chk(irq == 1, "R2 partial beat op done", irq, 1);
    readCheck(3'd6, 1, "R6 idle after op");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule